// File: doc/BRIEF.md
# Bidirectional 64-bit Latched Output Driver

This block turns a serial bit stream into 64 parallel output bits. Four 16-stage shift chains share one clock. Each chain has its own serial input, so one accepted input beat loads four bits. A direction input sets which way the bits travel along every chain.

A bank of level-sensitive latches sits behind the chains. It is transparent while the latch enable is high and holds its contents while the enable is low. The latched word then passes a polarity stage and a blanking stage before it reaches the outputs. A cascade output shows the last chain bit, so several blocks can be chained in series.

Input beats use a valid/ready handshake. The block never applies back-pressure: `in_ready` is held high out of reset, and a beat is taken on every rising clock edge where `in_valid` is high. When `in_valid` is low the chains keep their contents.

Top module: `bidir_latch_driver`

## Requirements
- R1: An active-low asynchronous reset clears every chain stage and every latch bit to 0.
- R2: A beat is accepted on a rising clock edge only when `in_valid` is 1. `in_ready` is always 1. With `in_valid` at 0 the chain contents and `cascade_out` do not change.
- R3: Chain k (k = 0..3) takes its bit from `ser_in[k]`. Its stage j (j = 0..15) feeds output bit index 4*j+k, where index 0 is output 1.
- R4: With `dir` = 1 (forward), the new bit enters stage 0 and every stage j takes the old value of stage j-1.
- R5: With `dir` = 0 (reverse), the new bit enters stage 15 and every stage j takes the old value of stage j+1.
- R6: `cascade_out` always equals stage 15 of chain 3 (bit index 63). In forward mode a bit that enters `ser_in[3]` appears there 16 accepted beats later.
- R7: While `latch_en` = 1 the latches follow the chain contents with no clock delay.
- R8: While `latch_en` = 0 the latches keep the value they had when the enable fell, even while new beats are shifted in.
- R9: With `pol_n` = 0 every latched bit is inverted on its way to `drv_out`. With `pol_n` = 1 the bits pass unchanged.
- R10: With `blank_n` = 0 all 64 bits of `drv_out` are 0, whatever the latch and polarity state. Blanking leaves the latch contents unchanged.
- R11: `latch_en`, `pol_n` and `blank_n` have no effect on shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir | input | 1 | Shift direction: 1 forward, 0 reverse |
| in_valid | input | 1 | An input beat is present on `ser_in` |
| in_ready | output | 1 | Always 1; the block never stalls |
| ser_in | input | 4 | One serial bit per chain |
| latch_en | input | 1 | 1 makes the latches transparent, 0 holds them |
| pol_n | input | 1 | 0 inverts the outputs |
| blank_n | input | 1 | 0 forces all outputs to 0 |
| drv_out | output | 64 | Conditioned parallel outputs |
| cascade_out | output | 1 | Last chain bit, for chaining blocks |

## Verification
Three kinds of beat stream are shifted in.

- A distinct 4-bit word per beat, sent in both directions. After a full chain length the whole 64-bit output word shows that each bit landed in the right chain and stage, which catches a swapped chain order or a mirrored stage order.
- A walking single one on chain 3. Its arrival at `cascade_out` after exactly 16 beats separates an off-by-one chain length from correct shifting.
- A stream sent while the latch is closed, blanking is on and polarity is inverted. This shows that the output controls affect neither shifting nor the held latch contents.

// File: rtl/bld_pkg.sv
package bld_pkg;
  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/bld_shift_chain.sv
module bld_shift_chain #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           dir,
  input  logic           ser_in,
  output logic [LEN-1:0] q,
  output logic [LEN-1:0] q_next
);
  import bld_pkg::*;

  logic [LEN-1:0] shifted;

  always_comb begin
    if (shift_dir_e'(dir) == DIR_FWD) shifted = {q[LEN-2:0], ser_in};
    else                              shifted = {ser_in, q[LEN-1:1]};
    q_next = shift_en ? shifted : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/bld_latch_bank.sv
module bld_latch_bank #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d_now,
  input  logic [W-1:0] d_next,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held <= '0;
    else if (le) held <= d_next;
  end

  assign q = le ? d_now : held;
endmodule

// File: rtl/bld_out_cond.sv
module bld_out_cond #(
  parameter int W = 64
) (
  input  logic         pol_n,
  input  logic         blank_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_comb begin
    if (!blank_n)    q = '0;
    else if (!pol_n) q = ~d;
    else             q = d;
  end
endmodule

// File: rtl/bidir_latch_driver.sv
module bidir_latch_driver #(
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             dir,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [NUM_CHAINS-1:0]            ser_in,
  input  logic                             latch_en,
  input  logic                             pol_n,
  input  logic                             blank_n,
  output logic [NUM_CHAINS*CHAIN_LEN-1:0]  drv_out,
  output logic                             cascade_out
);
  localparam int OUT_W = NUM_CHAINS * CHAIN_LEN;

  logic [CHAIN_LEN-1:0] chain_q   [NUM_CHAINS];
  logic [CHAIN_LEN-1:0] chain_nxt [NUM_CHAINS];
  logic [OUT_W-1:0]     sr_now, sr_next, lat_q;
  logic                 beat;

  assign in_ready = 1'b1;
  assign beat     = in_valid & in_ready;

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
    bld_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (beat),
      .dir      (dir),
      .ser_in   (ser_in[k]),
      .q        (chain_q[k]),
      .q_next   (chain_nxt[k])
    );
    for (genvar j = 0; j < CHAIN_LEN; j++) begin : g_stage
      assign sr_now [NUM_CHAINS*j+k] = chain_q[k][j];
      assign sr_next[NUM_CHAINS*j+k] = chain_nxt[k][j];
    end
  end

  bld_latch_bank #(.W(OUT_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .le     (latch_en),
    .d_now  (sr_now),
    .d_next (sr_next),
    .q      (lat_q)
  );

  bld_out_cond #(.W(OUT_W)) u_cond (
    .pol_n   (pol_n),
    .blank_n (blank_n),
    .d       (lat_q),
    .q       (drv_out)
  );

  assign cascade_out = chain_q[NUM_CHAINS-1][CHAIN_LEN-1];
endmodule

// File: rtl/bidir_latch_driver_chk.sv
module bidir_latch_driver_chk #(
  parameter int NUM_CHAINS = 4,
  parameter int OUT_W      = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dir,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [NUM_CHAINS-1:0] ser_in,
  input logic                  latch_en,
  input logic                  pol_n,
  input logic                  blank_n,
  input logic [OUT_W-1:0]      drv_out,
  input logic                  cascade_out
);
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready); // R2
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cascade_out)); // R2
  AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dir) |=> cascade_out == $past(ser_in[NUM_CHAINS-1])); // R5
  AST_TRANSP_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && blank_n) |-> drv_out[OUT_W-1] == (cascade_out ^ !pol_n)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_en && blank_n && pol_n && $past(!latch_en && blank_n && pol_n))
      |-> $stable(drv_out)); // R8
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> drv_out == '0); // R10
endmodule

bind bidir_latch_driver bidir_latch_driver_chk #(
  .NUM_CHAINS (NUM_CHAINS),
  .OUT_W      (NUM_CHAINS*CHAIN_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir         (dir),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .ser_in      (ser_in),
  .latch_en    (latch_en),
  .pol_n       (pol_n),
  .blank_n     (blank_n),
  .drv_out     (drv_out),
  .cascade_out (cascade_out)
);

// File: tb/bidir_latch_driver_bench.sv
module bidir_latch_driver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  ser_in = '0;
  logic        latch_en = 1'b1;
  logic        pol_n = 1'b1;
  logic        blank_n = 1'b1;
  logic [63:0] drv_out;
  logic        cascade_out;

  logic [63:0] model = '0;
  logic [63:0] snap;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bidir_latch_driver u_bidir_latch_driver (
    .clk(clk), .rst_n(rst_n), .dir(dir), .in_valid(in_valid),
    .in_ready(in_ready), .ser_in(ser_in), .latch_en(latch_en),
    .pol_n(pol_n), .blank_n(blank_n), .drv_out(drv_out),
    .cascade_out(cascade_out)
  );

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one beat; model follows R3/R4/R5; returns after the falling edge
  task automatic beat(input logic [3:0] bits, input logic valid);
    ser_in = bits;
    in_valid = valid;
    @(posedge clk);
    if (valid) begin
      for (int k = 0; k < 4; k++) begin
        if (dir) begin
          for (int j = 15; j > 0; j--) model[4*j+k] = model[4*(j-1)+k];
          model[k] = bits[k];
        end else begin
          for (int j = 0; j < 15; j++) model[4*j+k] = model[4*(j+1)+k];
          model[60+k] = bits[k];
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk64("R1 outputs in reset", drv_out, 64'h0);
    chk1("R1 cascade in reset", cascade_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R2 ready", in_ready, 1'b1);
  endtask

  task automatic t_forward();
    dir = 1'b1;
    beat(4'h8, 1'b1);
    chk1("R6 cascade before arrival", cascade_out, 1'b0);
    for (int i = 1; i < 16; i++) begin
      beat(4'(i * 5 + 3), 1'b1);
      if (i == 14) chk1("R6 cascade one beat early", cascade_out, 1'b0);
    end
    chk1("R6 cascade after 16 beats", cascade_out, 1'b1);
    chk64("R3 R4 forward word", drv_out, model);
  endtask

  task automatic t_reverse();
    dir = 1'b0;
    for (int i = 0; i < 16; i++) beat(4'(i * 7 + 1), 1'b1);
    chk64("R5 reverse word", drv_out, model);
    beat(4'h8, 1'b1);
    chk1("R5 R6 reverse entry", cascade_out, 1'b1);
    chk64("R5 one more beat", drv_out, model);
  endtask

  task automatic t_idle();
    snap = model;
    beat(4'hF, 1'b0);
    beat(4'h0, 1'b0);
    beat(4'hA, 1'b0);
    chk64("R2 no shift without valid", drv_out, snap);
  endtask

  task automatic t_latch();
    dir = 1'b1;
    latch_en = 1'b0;
    snap = model;
    for (int i = 0; i < 5; i++) beat(4'(i + 9), 1'b1);
    chk64("R8 held while shifting", drv_out, snap);
    #1 latch_en = 1'b1;
    #1 chk64("R7 transparent at once", drv_out, model);
  endtask

  task automatic t_pol();
    pol_n = 1'b0;
    #1 chk64("R9 inverted", drv_out, ~model);
    pol_n = 1'b1;
    #1 chk64("R9 passed", drv_out, model);
  endtask

  task automatic t_blank();
    @(negedge clk);
    latch_en = 1'b0;
    snap = model;
    blank_n = 1'b0;
    pol_n = 1'b0;
    #1 chk64("R10 blanked", drv_out, 64'h0);
    for (int i = 0; i < 16; i++) beat(4'(i * 3 + 2), 1'b1);
    chk64("R10 still blanked", drv_out, 64'h0);
    chk1("R11 cascade under controls", cascade_out, model[63]);
    blank_n = 1'b1;
    pol_n = 1'b1;
    #1 chk64("R10 latch kept under blank", drv_out, snap);
    latch_en = 1'b1;
    #1 chk64("R11 shift unaffected", drv_out, model);
  endtask

  task automatic t_async_reset();
    #1 rst_n = 1'b0;
    #1 chk64("R1 async clear", drv_out, 64'h0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_idle();
    t_latch();
    t_pol();
    t_blank();
    t_async_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule